// File: doc/BRIEF.md
# Scan-Line Sync and NMI Timer

This block divides a 6.5 MHz pixel clock into 64 µs scan lines. At the start of every line it raises a line sync pulse, and while the NMI generator is enabled it raises a coincident NMI pulse. A processor can use the NMI pulse to count blank lines in software. The block decodes I/O strobes: two output ports turn the NMI generator off and on, an input read with address bit 0 low starts vertical sync, and any output write ends it. No hardware timer limits how long vertical sync lasts.

A 3-bit scan-line counter steps once per line and is held at zero during vertical sync. A character fetch unit uses it as the pattern row. The block also merges the sync state and the incoming serial pixel into a two-bit composite level code.

Top module: `scan_sync_gen`

## Requirements
- R1: A line lasts exactly 416 clocks. Line sync (`hsync_o`) is high for the first 32 clocks of each line. The first line starts on the first clock after reset is released.
- R2: `nmi_o` is high exactly when `hsync_o` is high and the NMI generator is enabled. The generator is disabled after reset.
- R3: When `io_valid` and `io_write` are high with `io_addr` = 0xFD, the NMI generator is disabled from the next cycle. With 0xFE it is enabled from the next cycle. A write to any other address leaves the enable unchanged.
- R4: When `io_valid` is high and `io_write` is low with `io_addr` bit 0 = 0, and the generator is disabled, `vsync_o` rises in the next cycle. The same read while the generator is enabled, or any read with bit 0 = 1, leaves `vsync_o` low.
- R5: Any I/O write, to any address, clears `vsync_o` in the next cycle.
- R6: `row_o` is 0 after reset. It increments on the same clock edge where `hsync_o` rises, and wraps from 7 to 0.
- R7: From the cycle after `vsync_o` is first seen high, `row_o` is 0 for as long as vertical sync lasts. The line divider keeps running during vertical sync.
- R8: `video_o` is 0 (sync) whenever `hsync_o` or `vsync_o` is high, whatever the pixel value. Otherwise it is 1 (black) when `pixel_in` is 1 and 2 (white) when `pixel_in` is 0.
- R9: During and right after reset, `hsync_o` = 1, `nmi_o` = 0, `vsync_o` = 0, `nmi_en_o` = 0, `row_o` = 0 and `video_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 6.5 MHz pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_valid | input | 1 | One-cycle strobe marking an I/O access |
| io_write | input | 1 | 1 = output write, 0 = input read |
| io_addr | input | 8 | Low byte of the I/O port address |
| pixel_in | input | 1 | Serial pixel, 1 = black |
| hsync_o | output | 1 | Line sync pulse |
| nmi_o | output | 1 | NMI pulse, gated by the enable |
| vsync_o | output | 1 | Vertical sync in progress |
| nmi_en_o | output | 1 | NMI generator enable state |
| row_o | output | 3 | Scan-line counter, modulo 8 |
| video_o | output | 2 | Level code: 0 sync, 1 black, 2 white |

## Verification
The hardest states to reach are the ones that depend on an I/O access arriving in a particular enable state. Examples are a vertical-sync read while NMI is on, or a vertical sync that spans a line boundary and is then ended by a write that also enables NMI. The stimulus reaches them with a fixed script. Each access is issued at a known cycle, and every expected value is scheduled at an absolute cycle number computed from the 416-clock line. This covers row-counter wrap after seven released lines and the NMI pulse on the first line after the enabling write.

// File: rtl/scan_sync_pkg.sv
// Shared types for the scan-line sync timer.
// Assumes a two-bit level code consumed by an external level shifter.
package scan_sync_pkg;
    typedef enum logic [1:0] {
        LVL_SYNC  = 2'd0,
        LVL_BLACK = 2'd1,
        LVL_WHITE = 2'd2
    } level_e;
endpackage

// File: rtl/ssg_line_divider.sv
// Free-running line divider: counts LINE_CLKS clocks per line and drives
// line sync for the first SYNC_CLKS of them. Assumes SYNC_CLKS < LINE_CLKS.
module ssg_line_divider #(
    parameter int LINE_CLKS = 416,
    parameter int SYNC_CLKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic hsync,
    output logic line_wrap
);
    localparam int CW = $clog2(LINE_CLKS);
    localparam logic [CW-1:0] LAST  = CW'(LINE_CLKS - 1);
    localparam logic [CW-1:0] SEDGE = CW'(SYNC_CLKS);

    logic [CW-1:0] pos_q;

    // Advance the position within the line, wrapping at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n)              pos_q <= '0;
        else if (pos_q == LAST)  pos_q <= '0;
        else                     pos_q <= pos_q + 1'b1;
    end

    assign hsync     = (pos_q < SEDGE);
    assign line_wrap = (pos_q == LAST);
endmodule

// File: rtl/ssg_io_decode.sv
// I/O strobe decoder: holds the NMI enable and the vertical sync state.
// Assumes io_valid lasts one clock per access.
module ssg_io_decode #(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  OFF_PORT = 8'hFD,
    parameter logic [7:0]  ON_PORT  = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              nmi_en,
    output logic              vsync
);
    logic wr_hit;
    logic rd_vs;

    assign wr_hit = io_valid && io_write;
    assign rd_vs  = io_valid && !io_write && !io_addr[0] && !nmi_en;

    // Update the NMI enable on writes to the two control ports.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          nmi_en <= 1'b0;
        else if (wr_hit && io_addr == ADDR_W'(OFF_PORT))     nmi_en <= 1'b0;
        else if (wr_hit && io_addr == ADDR_W'(ON_PORT))      nmi_en <= 1'b1;
    end

    // Start vertical sync on a qualifying read, end it on any write.
    always_ff @(posedge clk) begin
        if (!rst_n)      vsync <= 1'b0;
        else if (wr_hit) vsync <= 1'b0;
        else if (rd_vs)  vsync <= 1'b1;
    end
endmodule

// File: rtl/ssg_row_counter.sv
// Modulo-2^ROW_W scan-line counter, cleared while vertical sync is held.
module ssg_row_counter #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    // Clear during vertical sync, otherwise step once per line.
    always_ff @(posedge clk) begin
        if (!rst_n)     row <= '0;
        else if (clear) row <= '0;
        else if (step)  row <= row + 1'b1;
    end
endmodule

// File: rtl/ssg_level_encoder.sv
// Composite level encoder: sync wins over pixel data. Purely combinational.
module ssg_level_encoder
    import scan_sync_pkg::*;
(
    input  logic       sync_any,
    input  logic       pixel,
    output logic [1:0] level
);
    level_e lvl;

    // Pick the level from sync state and pixel value.
    always_comb begin
        if (sync_any)   lvl = LVL_SYNC;
        else if (pixel) lvl = LVL_BLACK;
        else            lvl = LVL_WHITE;
    end

    assign level = lvl;
endmodule

// File: rtl/scan_sync_gen.sv
// Top of the scan-line sync and NMI timer. Ties the line divider, the I/O
// decoder, the row counter and the level encoder together.
// Assumes one clock of the 6.5 MHz pixel rate per cycle.
module scan_sync_gen #(
    parameter int         LINE_CLKS = 416,
    parameter int         SYNC_CLKS = 32,
    parameter int         ROW_W     = 3,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] OFF_PORT  = 8'hFD,
    parameter logic [7:0] ON_PORT   = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              pixel_in,
    output logic              hsync_o,
    output logic              nmi_o,
    output logic              vsync_o,
    output logic              nmi_en_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [1:0]        video_o
);
    logic line_wrap;

    ssg_line_divider #(.LINE_CLKS(LINE_CLKS), .SYNC_CLKS(SYNC_CLKS)) u_div (
        .clk(clk), .rst_n(rst_n), .hsync(hsync_o), .line_wrap(line_wrap)
    );

    ssg_io_decode #(.ADDR_W(ADDR_W), .OFF_PORT(OFF_PORT), .ON_PORT(ON_PORT)) u_io (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .nmi_en(nmi_en_o), .vsync(vsync_o)
    );

    ssg_row_counter #(.ROW_W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .clear(vsync_o), .step(line_wrap), .row(row_o)
    );

    ssg_level_encoder u_lvl (
        .sync_any(hsync_o || vsync_o), .pixel(pixel_in), .level(video_o)
    );

    assign nmi_o = hsync_o && nmi_en_o;
endmodule

// File: rtl/scan_sync_gen_chk.sv
// Property checker for scan_sync_gen, attached by bind below.
module scan_sync_gen_chk #(
    parameter int LINE_CLKS = 416,
    parameter int SYNC_CLKS = 32,
    parameter int ROW_W     = 3,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_valid,
    input logic              io_write,
    input logic [ADDR_W-1:0] io_addr,
    input logic              hsync_o,
    input logic              nmi_o,
    input logic              vsync_o,
    input logic              nmi_en_o,
    input logic [ROW_W-1:0]  row_o,
    input logic [1:0]        video_o
);
    logic [15:0] hi_run;
    logic [15:0] lo_run;

    // Count consecutive high and low cycles of line sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= hsync_o ? hi_run + 1'b1 : '0;
            lo_run <= hsync_o ? '0 : lo_run + 1'b1;
        end
    end

    AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_o) |-> hi_run == 16'(SYNC_CLKS)); // R1
    AST_LINE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_o) |-> lo_run == 16'(LINE_CLKS - SYNC_CLKS)); // R1
    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_en_o |-> !nmi_o); // R2
    AST_VSYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_o) |-> $past(!nmi_en_o && io_valid && !io_write && !io_addr[0])); // R4
    AST_VSYNC_END: assert property (@(posedge clk) disable iff (!rst_n)
        $past(io_valid && io_write) |-> !vsync_o); // R5
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_o) |-> ($rose(hsync_o) || $past(vsync_o))); // R6
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_o |=> row_o == '0); // R7
    AST_SYNC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync_o || vsync_o) |-> video_o == 2'd0); // R8
endmodule

bind scan_sync_gen scan_sync_gen_chk #(
    .LINE_CLKS(LINE_CLKS), .SYNC_CLKS(SYNC_CLKS), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_addr(io_addr), .hsync_o(hsync_o), .nmi_o(nmi_o), .vsync_o(vsync_o),
    .nmi_en_o(nmi_en_o), .row_o(row_o), .video_o(video_o)
);

// File: tb/scan_sync_gen_tb.sv
// Scoreboard bench: the driver queues expected values at absolute cycle
// numbers (clock edges since reset release); a monitor compares them.
module scan_sync_gen_tb;
    localparam int SEL_HS = 0, SEL_NMI = 1, SEL_VS = 2, SEL_ROW = 3, SEL_VID = 4, SEL_EN = 5;

    typedef struct {
        int    cyc;
        int    sel;
        int    val;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_valid = 1'b0;
    logic       io_write = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       pixel_in = 1'b0;
    logic       hsync_o, nmi_o, vsync_o, nmi_en_o;
    logic [2:0] row_o;
    logic [1:0] video_o;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    exp_t mon_item;

    scan_sync_gen u_dut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .pixel_in(pixel_in), .hsync_o(hsync_o), .nmi_o(nmi_o),
        .vsync_o(vsync_o), .nmi_en_o(nmi_en_o), .row_o(row_o), .video_o(video_o)
    );

    always #5 clk = ~clk;

    // Count clock edges taken after reset release.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    function automatic int observe(int sel);
        case (sel)
            SEL_HS:  return int'(hsync_o);
            SEL_NMI: return int'(nmi_o);
            SEL_VS:  return int'(vsync_o);
            SEL_ROW: return int'(row_o);
            SEL_VID: return int'(video_o);
            default: return int'(nmi_en_o);
        endcase
    endfunction

    // Monitor: compare due items away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            mon_item = sb.pop_front();
            checks++;
            if (mon_item.cyc != cyc || observe(mon_item.sel) != mon_item.val) begin
                fails++;
                $display("FAIL %s cycle %0d sel %0d: actual %0d expected %0d",
                         mon_item.req, mon_item.cyc, mon_item.sel,
                         observe(mon_item.sel), mon_item.val);
            end
        end
    end

    task automatic expect_at(int c, int sel, int val, string req);
        exp_t e;
        e.cyc = c; e.sel = sel; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
        #1;
    endtask

    task automatic io_op(int at, bit wr, logic [7:0] addr);
        wait_cyc(at);
        io_valid = 1'b1; io_write = wr; io_addr = addr;
        wait_cyc(at + 1);
        io_valid = 1'b0; io_write = 1'b0;
    endtask

    task automatic set_pixel(int at, bit v);
        wait_cyc(at);
        pixel_in = v;
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    // Driver script.
    initial begin
        // R9 reset state, sampled while reset is held
        expect_at(0, SEL_HS, 1, "R9");
        expect_at(0, SEL_NMI, 0, "R9");
        expect_at(0, SEL_VS, 0, "R9");
        expect_at(0, SEL_ROW, 0, "R9");
        expect_at(0, SEL_VID, 0, "R9");
        expect_at(0, SEL_EN, 0, "R9");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 sync width and period, R8 levels, R6 first step
        expect_at(31, SEL_HS, 1, "R1");
        expect_at(32, SEL_HS, 0, "R1");
        expect_at(32, SEL_VID, 2, "R8");
        expect_at(100, SEL_VID, 1, "R8");
        expect_at(120, SEL_VID, 2, "R8");
        expect_at(415, SEL_ROW, 0, "R6");
        expect_at(415, SEL_HS, 0, "R1");
        expect_at(416, SEL_HS, 1, "R1");
        expect_at(416, SEL_ROW, 1, "R6");
        expect_at(420, SEL_VID, 0, "R8");
        expect_at(455, SEL_VID, 1, "R8");
        set_pixel(90, 1'b1);
        set_pixel(110, 1'b0);
        set_pixel(410, 1'b1);
        set_pixel(460, 1'b0);

        // R3 enable, R2 pulses coincide with line sync
        expect_at(501, SEL_EN, 1, "R3");
        expect_at(832, SEL_NMI, 1, "R2");
        expect_at(840, SEL_ROW, 2, "R6");
        expect_at(863, SEL_NMI, 1, "R2");
        expect_at(864, SEL_NMI, 0, "R2");
        io_op(500, 1'b1, 8'hFE);

        // R4 read ignored while NMI enabled
        expect_at(901, SEL_VS, 0, "R4");
        expect_at(950, SEL_VS, 0, "R4");
        io_op(900, 1'b0, 8'hFE);

        // R3 disable, R2 no pulse while disabled
        expect_at(1001, SEL_EN, 0, "R3");
        expect_at(1248, SEL_HS, 1, "R2");
        expect_at(1248, SEL_NMI, 0, "R2");
        expect_at(1248, SEL_ROW, 3, "R6");
        io_op(1000, 1'b1, 8'hFD);

        // R4 read with bit 0 high ignored
        expect_at(1301, SEL_VS, 0, "R4");
        io_op(1300, 1'b0, 8'hFF);

        // R4 vsync start, R7 row held and divider running, R8 sync priority
        expect_at(1401, SEL_VS, 1, "R4");
        expect_at(1402, SEL_ROW, 0, "R7");
        expect_at(1500, SEL_VID, 0, "R8");
        expect_at(1664, SEL_HS, 1, "R7");
        expect_at(1700, SEL_HS, 0, "R7");
        expect_at(1700, SEL_ROW, 0, "R7");
        io_op(1400, 1'b0, 8'hFE);
        set_pixel(1450, 1'b1);
        set_pixel(1550, 1'b0);

        // R5 any write ends vsync, R3 other port leaves enable alone
        expect_at(1801, SEL_VS, 0, "R5");
        expect_at(1801, SEL_EN, 0, "R3");
        expect_at(2079, SEL_ROW, 0, "R6");
        expect_at(2080, SEL_ROW, 1, "R6");
        io_op(1800, 1'b1, 8'h7F);

        // R6 wrap from 7 to 0
        expect_at(4991, SEL_ROW, 7, "R6");
        expect_at(4992, SEL_ROW, 0, "R6");

        // R5 enabling write also ends vsync, R2 pulse on the next line
        expect_at(5101, SEL_VS, 1, "R4");
        expect_at(5201, SEL_VS, 0, "R5");
        expect_at(5201, SEL_EN, 1, "R3");
        expect_at(5408, SEL_NMI, 1, "R2");
        io_op(5100, 1'b0, 8'h00);
        io_op(5200, 1'b1, 8'hFE);

        wait_cyc(5410);
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end
endmodule